// File: doc/BRIEF.md
# Table Read-Entry Mailbox Responder

This block answers requests to read one entry of a small attribute table through a mailbox that carries data objects one 32-bit word at a time. A host writes a request object of at least three dwords: an identification dword, a length dword and a dword naming the entry to fetch. The responder checks the identification, the length and the request fields. Requests that fail a check are dropped without any answer.

For an accepted request, the responder looks the entry up in an on-chip descriptor table. The table stores a base dword address and a byte length for each entry. The responder then streams back a three-dword response header followed by the entry payload, which it reads from an external word memory. The header carries the handle of the following entry, or 0xFFFF after the final one. A host can therefore start at handle 0 and walk the whole table, feeding each returned handle into its next request. A handle outside the populated table produces no response and a one-cycle error pulse.

Top module: `tabrd_responder`

## Requirements
- R1: After reset, rsp_valid and err_o are 0 and req_ready is 1.
- R2: Request dword 0 must hold vendor code 0x1E98 in bits [15:0] and object type 2 in bits [23:16]. Any other value drops the request without a response.
- R3: A request whose dword 1 length field (bits [17:0], in dwords) is below 3 is dropped. A request that ends (req_last) before its third dword is also dropped.
- R4: Request dword 2 must carry request code 0 in bits [7:0] and table type 0 in bits [15:8], otherwise it is dropped. Bits [31:16] give the entry handle.
- R5: A well-formed request whose handle is not below ent_count (or not below the table depth) gets no response. err_o is 1 for exactly the cycle after its last dword is accepted.
- R6: Response dword 0 is 0x00021E98: vendor code in [15:0], type 2 in [23:16], zero in [31:24].
- R7: Response dword 1 equals ceil((12 + entry byte length) / 4).
- R8: Response dword 2 has code 0 in [7:0] and table type 0 in [15:8]. Bits [31:16] hold handle+1, or 0xFFFF when the handle equals ent_count-1.
- R9: Payload dword i is the memory word at mem_addr = base + i. In the final payload dword, the bytes beyond the entry length are zero; byte k sits in bits [8k+7:8k].
- R10: While rsp_valid is 1 and rsp_ready is 0, rsp_data and rsp_last hold. rsp_last is 1 only on the final dword. A zero-length entry gives a 3-dword response with rsp_last on dword 2.
- R11: req_ready is 0 from the acceptance of a valid request's last dword until the response's last dword is accepted, and 1 otherwise.
- R12: A table write (tbl_we) stores tbl_base and tbl_len at tbl_idx. Later reads of that handle use the new values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tbl_we | input | 1 | Descriptor write strobe |
| tbl_idx | input | 4 | Descriptor index to write |
| tbl_base | input | 16 | Entry base dword address |
| tbl_len | input | 12 | Entry length in bytes |
| ent_count | input | 5 | Number of populated entries |
| req_valid | input | 1 | Request dword valid |
| req_ready | output | 1 | Responder accepts a request dword |
| req_data | input | 32 | Request dword |
| req_last | input | 1 | Final dword of the request object |
| rsp_valid | output | 1 | Response dword valid |
| rsp_ready | input | 1 | Receiver accepts a response dword |
| rsp_data | output | 32 | Response dword |
| rsp_last | output | 1 | Final dword of the response object |
| mem_addr | output | 16 | Payload word address |
| mem_rdata | input | 32 | Payload word, combinational from mem_addr |
| err_o | output | 1 | Handle-out-of-range pulse |

## Verification
The assertions take for granted that mem_rdata is a pure function of mem_addr within a cycle. Without that, the hold check on a stalled response could not hold. They also assume that ent_count and the descriptor of an entry in flight are not rewritten while its response streams out. The bench keeps to these assumptions: it models the memory as a fixed function of the address, and it changes the table and the entry count only between transactions. Its random back-pressure and random trailing request dwords stay within the handshake rules.

// File: rtl/tabrd_pkg.sv
// Shared constants for the table read-entry responder.
package tabrd_pkg;
    localparam logic [15:0] VENDOR_CODE = 16'h1E98;
    localparam logic [7:0]  OBJ_TABLE   = 8'h02;
    localparam logic [15:0] END_HANDLE  = 16'hFFFF;
    localparam int          HDR_DWORDS  = 3;
    localparam int          LENF_W      = 18;
endpackage

// File: rtl/tabrd_req_parse.sv
// Request parser: counts the dwords of an incoming object and checks the
// identification, length and request fields.
// Assumes: accept is valid&&ready; done pulses on the accepted last dword.
module tabrd_req_parse
    import tabrd_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        accept,
    input  logic [31:0] data,
    input  logic        last,
    output logic        done,
    output logic        fmt_ok,
    output logic [15:0] handle
);
    logic [1:0]  wcnt_q;
    logic        id_ok_q;
    logic        len_ok_q;
    logic [31:0] sel_q;
    logic [31:0] sel_now;

    // Track the dword position and capture the checked fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wcnt_q   <= '0;
            id_ok_q  <= 1'b0;
            len_ok_q <= 1'b0;
            sel_q    <= '0;
        end else if (accept) begin
            if (last)
                wcnt_q <= '0;
            else if (wcnt_q != 2'd3)
                wcnt_q <= wcnt_q + 2'd1;
            case (wcnt_q)
                2'd0: id_ok_q  <= (data[23:0] == {OBJ_TABLE, VENDOR_CODE});
                2'd1: len_ok_q <= (data[LENF_W-1:0] >= LENF_W'(HDR_DWORDS));
                2'd2: sel_q    <= data;
                default: ;
            endcase
        end
    end

    // Combine stored checks with the selection dword (live if it is last).
    always_comb begin
        sel_now = (wcnt_q == 2'd2) ? data : sel_q;
        done    = accept && last;
        fmt_ok  = (wcnt_q >= 2'd2) && id_ok_q && len_ok_q && (sel_now[15:0] == 16'h0000);
        handle  = sel_now[31:16];
    end
endmodule

// File: rtl/tabrd_desc_table.sv
// Descriptor table: base dword address and byte length per entry.
// Assumes: one write port, combinational read.
module tabrd_desc_table #(
    parameter int ENTRIES = 16,
    parameter int ADDR_W  = 16,
    parameter int LEN_W   = 12,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  widx,
    input  logic [ADDR_W-1:0] wbase,
    input  logic [LEN_W-1:0]  wlen,
    input  logic [IDX_W-1:0]  ridx,
    output logic [ADDR_W-1:0] rbase,
    output logic [LEN_W-1:0]  rlen
);
    logic [ADDR_W-1:0] base_q [ENTRIES];
    logic [LEN_W-1:0]  len_q  [ENTRIES];

    // Clear on reset, otherwise store the written descriptor.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) begin
                base_q[i] <= '0;
                len_q[i]  <= '0;
            end
        end else if (we) begin
            base_q[widx] <= wbase;
            len_q[widx]  <= wlen;
        end
    end

    // Read the selected descriptor.
    always_comb begin
        rbase = base_q[ridx];
        rlen  = len_q[ridx];
    end
endmodule

// File: rtl/tabrd_rsp_build.sv
// Response builder: emits the 3-dword header then the payload dwords on a
// valid/ready stream, zero-padding the tail of the last payload dword.
// Assumes: mem_rdata follows mem_addr combinationally; start only when idle.
module tabrd_rsp_build
    import tabrd_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int LEN_W  = 12,
    localparam int CNT_W = LEN_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] base,
    input  logic [LEN_W-1:0]  len,
    input  logic [15:0]       next_handle,
    input  logic              rsp_ready,
    input  logic [31:0]       mem_rdata,
    output logic              rsp_valid,
    output logic [31:0]       rsp_data,
    output logic              rsp_last,
    output logic [ADDR_W-1:0] mem_addr
);
    logic              active_q;
    logic [CNT_W-1:0]  idx_q;
    logic [ADDR_W-1:0] base_q;
    logic [LEN_W-1:0]  len_q;
    logic [15:0]       next_q;
    logic [CNT_W-1:0]  pay_dw;
    logic [CNT_W-1:0]  total_dw;
    logic [CNT_W-1:0]  pay_idx;
    logic [31:0]       pad_mask;

    // Latch the entry on start and step through the dwords on each handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            idx_q    <= '0;
            base_q   <= '0;
            len_q    <= '0;
            next_q   <= '0;
        end else if (start) begin
            active_q <= 1'b1;
            idx_q    <= '0;
            base_q   <= base;
            len_q    <= len;
            next_q   <= next_handle;
        end else if (active_q && rsp_ready) begin
            if (rsp_last)
                active_q <= 1'b0;
            else
                idx_q <= idx_q + CNT_W'(1);
        end
    end

    // Size arithmetic, payload address and tail mask.
    always_comb begin
        pay_dw   = (CNT_W'(len_q) + CNT_W'(3)) >> 2;
        total_dw = pay_dw + CNT_W'(HDR_DWORDS);
        pay_idx  = idx_q - CNT_W'(HDR_DWORDS);
        mem_addr = base_q + ADDR_W'(pay_idx);
        case (len_q[1:0])
            2'd1:    pad_mask = 32'h0000_00FF;
            2'd2:    pad_mask = 32'h0000_FFFF;
            2'd3:    pad_mask = 32'h00FF_FFFF;
            default: pad_mask = 32'hFFFF_FFFF;
        endcase
    end

    // Select the output dword for the current position.
    always_comb begin
        rsp_valid = active_q;
        rsp_last  = active_q && (idx_q == total_dw - CNT_W'(1));
        case (idx_q)
            CNT_W'(0): rsp_data = {8'h00, OBJ_TABLE, VENDOR_CODE};
            CNT_W'(1): rsp_data = 32'(total_dw);
            CNT_W'(2): rsp_data = {next_q, 8'h00, 8'h00};
            default:   rsp_data = rsp_last ? (mem_rdata & pad_mask) : mem_rdata;
        endcase
    end

    AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data) && $stable(rsp_last))); // R10
    AST_END_ON_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rsp_valid) |-> $past(rsp_last)); // R10
    AST_TAIL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_last && idx_q >= CNT_W'(3) && len_q[1:0] != 2'd0)
            |-> ((rsp_data >> (8 * len_q[1:0])) == 32'h0)); // R9
endmodule

// File: rtl/tabrd_responder.sv
// Top: joins the parser, descriptor table and response builder, checks the
// handle range and computes the following-entry handle.
// Assumes: ent_count and table contents are steady while a response streams.
module tabrd_responder
    import tabrd_pkg::*;
#(
    parameter int ENTRIES  = 16,
    parameter int ADDR_W   = 16,
    parameter int LEN_W    = 12,
    localparam int IDX_W   = $clog2(ENTRIES),
    localparam int ECNT_W  = $clog2(ENTRIES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tbl_we,
    input  logic [IDX_W-1:0]  tbl_idx,
    input  logic [ADDR_W-1:0] tbl_base,
    input  logic [LEN_W-1:0]  tbl_len,
    input  logic [ECNT_W-1:0] ent_count,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [31:0]       req_data,
    input  logic              req_last,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [31:0]       rsp_data,
    output logic              rsp_last,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [31:0]       mem_rdata,
    output logic              err_o
);
    logic              p_done;
    logic              p_fmt_ok;
    logic [15:0]       p_handle;
    logic [ADDR_W-1:0] d_base;
    logic [LEN_W-1:0]  d_len;
    logic              in_range;
    logic              go;
    logic [15:0]       nxt_handle;
    logic              err_q;

    assign req_ready = !rsp_valid;

    tabrd_req_parse u_parse (
        .clk    (clk),
        .rst_n  (rst_n),
        .accept (req_valid && req_ready),
        .data   (req_data),
        .last   (req_last),
        .done   (p_done),
        .fmt_ok (p_fmt_ok),
        .handle (p_handle)
    );

    tabrd_desc_table #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_table (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (tbl_we),
        .widx  (tbl_idx),
        .wbase (tbl_base),
        .wlen  (tbl_len),
        .ridx  (p_handle[IDX_W-1:0]),
        .rbase (d_base),
        .rlen  (d_len)
    );

    // Range check and following-entry handle.
    always_comb begin
        in_range   = (p_handle < 16'(ent_count)) && (p_handle < 16'(ENTRIES));
        go         = p_done && p_fmt_ok && in_range;
        nxt_handle = (p_handle == 16'(ent_count) - 16'd1) ? END_HANDLE : p_handle + 16'd1;
    end

    // One-cycle pulse for a well-formed request naming a missing entry.
    always_ff @(posedge clk) begin
        if (!rst_n)
            err_q <= 1'b0;
        else
            err_q <= p_done && p_fmt_ok && !in_range;
    end
    assign err_o = err_q;

    tabrd_rsp_build #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_build (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (go),
        .base        (d_base),
        .len         (d_len),
        .next_handle (nxt_handle),
        .rsp_ready   (rsp_ready),
        .mem_rdata   (mem_rdata),
        .rsp_valid   (rsp_valid),
        .rsp_data    (rsp_data),
        .rsp_last    (rsp_last),
        .mem_addr    (mem_addr)
    );

    AST_ERR_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> !rsp_valid); // R5
    AST_ERR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> !err_o); // R5
    AST_NO_REQ_IN_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready); // R11
    AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rsp_valid) |-> $past(req_valid && req_last)); // R11
endmodule

// File: tb/test_tabrd_responder.sv
`timescale 1ns/1ps
module test_tabrd_responder;
    localparam int NENT = 16;
    localparam int USED = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tbl_we = 1'b0;
    logic [3:0]  tbl_idx = '0;
    logic [15:0] tbl_base = '0;
    logic [11:0] tbl_len = '0;
    logic [4:0]  ent_count = 5'(USED);
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_data = '0;
    logic        req_last = 1'b0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b0;
    logic [31:0] rsp_data;
    logic        rsp_last;
    logic [15:0] mem_addr;
    logic [31:0] mem_rdata;
    logic        err_o;

    int checks = 0;
    int failures = 0;
    int eb [NENT];
    int el [NENT];

    always #2.5 clk = ~clk;

    function automatic logic [31:0] memf(input logic [15:0] a);
        return {a ^ 16'h5A3C, ~a};
    endfunction
    assign mem_rdata = memf(mem_addr);

    tabrd_responder i_tabrd_responder (
        .clk(clk), .rst_n(rst_n), .tbl_we(tbl_we), .tbl_idx(tbl_idx),
        .tbl_base(tbl_base), .tbl_len(tbl_len), .ent_count(ent_count),
        .req_valid(req_valid), .req_ready(req_ready), .req_data(req_data),
        .req_last(req_last), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .rsp_data(rsp_data), .rsp_last(rsp_last), .mem_addr(mem_addr),
        .mem_rdata(mem_rdata), .err_o(err_o)
    );

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic summary;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        summary();
    end

    // Expected dword k of the response for handle h (R6..R9).
    function automatic logic [31:0] exp_word(input int h, input int k);
        int len = el[h];
        int ndw = (len + 3) / 4;
        logic [31:0] w;
        if (k == 0) return 32'h0002_1E98;
        if (k == 1) return 32'((12 + len + 3) / 4);
        if (k == 2) return {((h == USED - 1) ? 16'hFFFF : 16'(h + 1)), 16'h0000};
        w = memf(16'(eb[h] + k - 3));
        if (k == ndw + 2 && (len % 4) != 0)
            w = w & ((32'h1 << (8 * (len % 4))) - 32'h1);
        return w;
    endfunction

    task automatic wr_tbl(input int i, input int b, input int l);
        @(negedge clk);
        tbl_we = 1'b1; tbl_idx = 4'(i); tbl_base = 16'(b); tbl_len = 12'(l);
        @(posedge clk);
        @(negedge clk);
        tbl_we = 1'b0;
        eb[i] = b & 16'hFFFF; el[i] = l;
    endtask

    // Send n dwords; ends on the negedge after the last accepted dword.
    task automatic send(input logic [31:0] w0, input logic [31:0] w1, input logic [31:0] w2, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            req_valid = 1'b1;
            req_data  = (i == 0) ? w0 : (i == 1) ? w1 : (i == 2) ? w2 : $urandom;
            req_last  = (i == n - 1);
            while (!req_ready) @(negedge clk);
            @(posedge clk);
        end
        @(negedge clk);
        req_valid = 1'b0; req_last = 1'b0;
    endtask

    task automatic read_entry(input int h, input int extra);
        int total = 3 + (el[h] + 3) / 4;
        int cnt = 0;
        int guard = 0;
        logic done = 1'b0;
        send(32'h0002_1E98, 32'd3 + 32'(extra), {16'(h), 16'h0000}, 3 + extra);
        chk(rsp_valid == 1'b1 && req_ready == 1'b0, "R11 busy after request", {30'd0, rsp_valid, req_ready}, 32'h2);
        while (!done && guard < 5000) begin
            guard++;
            if (guard > 1) @(negedge clk);
            rsp_ready = ($urandom % 4) != 0;
            if (rsp_valid && rsp_ready) begin
                chk(rsp_data == exp_word(h, cnt), $sformatf("R6-9 h=%0d word%0d", h, cnt), rsp_data, exp_word(h, cnt));
                chk(rsp_last == (cnt == total - 1), $sformatf("R10 last flag h=%0d word%0d", h, cnt), 32'(rsp_last), 32'(cnt == total - 1));
                if (rsp_last) done = 1'b1;
                cnt++;
                @(posedge clk);
            end
        end
        @(negedge clk);
        rsp_ready = 1'b0;
        chk(cnt == total, $sformatf("R7 dword count h=%0d", h), 32'(cnt), 32'(total));
        chk(req_ready == 1'b1 && rsp_valid == 1'b0, "R11 idle after response", {30'd0, rsp_valid, req_ready}, 32'h1);
    endtask

    task automatic expect_drop(input logic [31:0] w0, input logic [31:0] w1, input logic [31:0] w2, input int n, input string tag);
        logic seen = 1'b0;
        send(w0, w1, w2, n);
        chk(err_o == 1'b0, {tag, " no error"}, 32'(err_o), 32'd0);
        for (int i = 0; i < 6; i++) begin
            if (rsp_valid) seen = 1'b1;
            @(negedge clk);
        end
        chk(!seen && req_ready, {tag, " dropped"}, {30'd0, seen, req_ready}, 32'h1);
    endtask

    task automatic expect_err(input int h);
        logic seen = 1'b0;
        send(32'h0002_1E98, 32'd3, {16'(h), 16'h0000}, 3);
        chk(err_o == 1'b1, $sformatf("R5 error pulse h=%0d", h), 32'(err_o), 32'd1);
        for (int i = 0; i < 5; i++) begin
            if (rsp_valid) seen = 1'b1;
            @(negedge clk);
        end
        chk(err_o == 1'b0 && !seen, $sformatf("R5 single pulse no response h=%0d", h), {30'd0, err_o, seen}, 32'h0);
    endtask

    initial begin
        void'($urandom(32'h1234_5678));
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(rsp_valid == 1'b0 && err_o == 1'b0, "R1 outputs idle in reset", {30'd0, rsp_valid, err_o}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1 && rsp_valid == 1'b0 && err_o == 1'b0, "R1 reset state",
            {29'd0, req_ready, rsp_valid, err_o}, 32'h4);

        for (int i = 0; i < NENT; i++)
            wr_tbl(i, int'($urandom % 60000), (i < 5) ? i : int'($urandom % 41));

        // Directed: short entries cover zero length and every tail size (R9, R10).
        for (int h = 0; h < 5; h++) read_entry(h, 0);
        read_entry(USED - 1, 0);                    // R8 end marker
        read_entry(6, 2);                           // trailing request dwords ignored

        // Drops (R2, R3, R4).
        expect_drop(32'h0002_1E99, 32'd3, 32'h0001_0000, 3, "R2 bad vendor");
        expect_drop(32'h0001_1E98, 32'd3, 32'h0001_0000, 3, "R2 bad type");
        expect_drop(32'h0002_1E98, 32'd2, 32'h0001_0000, 3, "R3 length field 2");
        expect_drop(32'h0002_1E98, 32'd3, 32'h0001_0000, 2, "R3 two dwords");
        expect_drop(32'h0002_1E98, 32'd3, 32'h0001_0000, 1, "R3 one dword");
        expect_drop(32'h0002_1E98, 32'd3, 32'h0001_0001, 3, "R4 bad request code");
        expect_drop(32'h0002_1E98, 32'd3, 32'h0001_0100, 3, "R4 bad table type");

        // Out of range (R5).
        expect_err(USED);
        expect_err(16'hFFFF);

        // Rewrite a descriptor (R12).
        wr_tbl(5, 16'hFFF0, 37);
        read_entry(5, 0);

        // Random walk.
        for (int it = 0; it < 40; it++) begin
            int h = int'($urandom % NENT);
            if (h < USED) read_entry(h, int'($urandom % 3));
            else expect_err(h);
        end
        summary();
    end
endmodule